// File: doc/BRIEF.md
# Variable-Count Round-Robin Multi-Arbiter

This block picks several requesters out of a request vector in one cycle and keeps the choice fair over time. Each cycle it grants up to k of N requests. The budget k comes from a runtime slot-count input and is clamped to a fixed maximum M. Grants go in round-robin order, starting at a registered head position. The requests at or above the head are served first. If budget remains, the search wraps to the lowest indices.

No single encoder has to wrap around the vector. Two M-select priority encoders built on saturating running sums run side by side. One sees only the requests at or above the head. The other sees every request. A merge stage takes the picks of the first encoder first. It then fills the remaining slots with the unmasked picks that lie below the head. The merged picks drive three things: an OR-ed one-hot grant vector, ready bits equal to the grants, and consecutive output lanes that carry the winners' data. After each cycle with a grant, the head register moves to one past the last grant in round-robin order.

Top module: `vcrr_arbiter`

## Requirements
- R1: The number of set grant bits equals min(k, number of set request bits), where k = min(avail_slots, M).
- R2: A grant bit is set only where the matching request bit is set.
- R3: The grants are the first k requests met when scanning indices upward from the head position, wrapping from N−1 to 0.
- R4: After a cycle with at least one grant, the head becomes one past the index of the last grant in that scan order, and 0 when that index is N−1.
- R5: When no request is set or k is 0, no grant is given and the head keeps its value.
- R6: avail_slots values above M act as M.
- R7: Output lane s (s = 0 upward) is valid and carries the data word of the s-th grant in scan order. The valid lanes always form the contiguous group starting at lane 0, one lane per grant.
- R8: ready equals grant, bit for bit, in the same cycle.
- R9: Synchronous active-high reset sets the head to 0, so the first scan after reset starts at index 0.
- R10: A request that stays set while k is nonzero is granted within N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_REQ | Request bit per requester |
| req_data | input | N_REQ*DATA_W | Data word per requester, packed by index |
| avail_slots | input | SLOT_W | Runtime grant budget, clamped to M_MAX |
| grant | output | N_REQ | One-hot-OR grant vector |
| ready | output | N_REQ | Per-requester acceptance, equal to grant |
| lane_valid | output | M_MAX | Valid bit per output lane |
| lane_data | output | M_MAX*DATA_W | Packed data of the granted requesters |

## Verification
The bench targets the wrap case, where the budget exceeds the requests above the head. A merge that skipped duplicates badly would grant one index twice, and then lose a lane or give too few grants. It drives a zero budget and an empty request vector; a design that moved the head anyway would show a shifted scan start on the next cycle. Budgets above M test the clamp, which a wrong design would overrun or truncate. A held request under a budget of one tests the head update: an off-by-one in that update would starve a requester or skip one each round.

// File: rtl/vcrr_pkg.sv
package vcrr_pkg;

    // Which request view an encoder instance works on.
    typedef enum logic {
        ENC_ABOVE_HEAD = 1'b0,
        ENC_ALL        = 1'b1
    } enc_view_e;

    // Width of a counter able to hold the values 0..max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val < 1) ? 1 : $clog2(max_val + 1);
    endfunction

    // Width of an index into n entries.
    function automatic int idx_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/vcrr_msel_enc.sv
module vcrr_msel_enc
    import vcrr_pkg::*;
#(
    parameter int N_REQ = 8,
    parameter int M_MAX = 3,
    parameter int CW    = cnt_width(M_MAX)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_REQ-1:0]             req_vec,
    input  logic [CW-1:0]                limit,
    output logic [M_MAX-1:0][N_REQ-1:0]  pick,
    output logic [CW-1:0]                pick_cnt
);

    // Saturating running sum per index position.
    logic [N_REQ-1:0][CW-1:0] sum;
    // Thermometer form of each pick number.
    logic [M_MAX-1:0][N_REQ-1:0] therm;

    always_comb begin
        logic [CW-1:0] run;
        run = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (req_vec[i] && (run < limit)) begin
                run = run + 1'b1;
            end
            sum[i] = run;
        end
    end

    genvar gj, gi;
    generate
        for (gj = 0; gj < M_MAX; gj++) begin : g_pick
            for (gi = 0; gi < N_REQ; gi++) begin : g_bit
                assign therm[gj][gi] = (sum[gi] > CW'(gj));
                if (gi == 0) begin : g_first
                    assign pick[gj][gi] = therm[gj][gi];
                end else begin : g_rest
                    assign pick[gj][gi] = therm[gj][gi] & ~therm[gj][gi-1];
                end
            end
        end
    endgenerate

    assign pick_cnt = sum[N_REQ-1];

    // R1: never more picks than the limit allows
    a_r1_enc_limit: assert property (@(posedge clk) disable iff (rst)
        pick_cnt <= limit);

    // R2: an encoder only picks positions it was shown
    a_r2_enc_subset: assert property (@(posedge clk) disable iff (rst)
        ((pick[0] | pick[M_MAX-1]) & ~req_vec) == '0);

endmodule

// File: rtl/vcrr_merge.sv
module vcrr_merge
    import vcrr_pkg::*;
#(
    parameter int N_REQ  = 8,
    parameter int M_MAX  = 3,
    parameter int DATA_W = 16,
    parameter int CW     = cnt_width(M_MAX),
    parameter int IW     = idx_width(N_REQ)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [M_MAX-1:0][N_REQ-1:0]   pick_hi,
    input  logic [CW-1:0]                 cnt_hi,
    input  logic [M_MAX-1:0][N_REQ-1:0]   pick_all,
    input  logic [CW-1:0]                 limit,
    input  logic [IW-1:0]                 head,
    input  logic [N_REQ-1:0][DATA_W-1:0]  req_data,
    output logic [N_REQ-1:0]              grant,
    output logic [M_MAX-1:0]              lane_valid,
    output logic [M_MAX-1:0][DATA_W-1:0]  lane_data,
    output logic [IW-1:0]                 head_nxt
);

    logic [N_REQ-1:0]            below_head;
    logic [M_MAX-1:0][N_REQ-1:0] slot_sel;
    logic [IW-1:0]               last_idx;
    logic                        any_grant;

    always_comb begin
        for (int i = 0; i < N_REQ; i++) begin
            below_head[i] = (IW'(i) < head);
        end
    end

    // Slot s: masked picks first, then wrapped picks below the head.
    always_comb begin
        int u;
        for (int s = 0; s < M_MAX; s++) begin
            slot_sel[s] = '0;
            u = 0;
            if (CW'(s) < cnt_hi) begin
                slot_sel[s] = pick_hi[s];
            end else if (CW'(s) < limit) begin
                u = s - int'(cnt_hi);
                if ((pick_all[u] & below_head) != '0) begin
                    slot_sel[s] = pick_all[u];
                end
            end
        end
    end

    // Grant OR, lane packing and last-granted index.
    always_comb begin
        grant      = '0;
        lane_valid = '0;
        lane_data  = '0;
        last_idx   = head;
        any_grant  = 1'b0;
        for (int s = 0; s < M_MAX; s++) begin
            for (int i = 0; i < N_REQ; i++) begin
                if (slot_sel[s][i]) begin
                    lane_valid[s] = 1'b1;
                    lane_data[s]  = req_data[i];
                    last_idx      = IW'(i);
                    any_grant     = 1'b1;
                end
            end
            grant = grant | slot_sel[s];
        end
    end

    always_comb begin
        if (!any_grant) begin
            head_nxt = head;
        end else if (last_idx == IW'(N_REQ - 1)) begin
            head_nxt = '0;
        end else begin
            head_nxt = last_idx + 1'b1;
        end
    end

    // R7: valid lanes fill from lane 0 without gaps
    a_r7_lane_contig: assert property (@(posedge clk) disable iff (rst)
        ((lane_valid & (lane_valid + 1'b1)) == '0));

    // R7: one lane per grant, so no index is granted twice
    a_r7_lane_count: assert property (@(posedge clk) disable iff (rst)
        $countones(lane_valid) == $countones(grant));

    // R4: next head stays a legal index
    a_r4_head_range: assert property (@(posedge clk) disable iff (rst)
        int'(head_nxt) < N_REQ);

endmodule

// File: rtl/vcrr_arbiter.sv
module vcrr_arbiter
    import vcrr_pkg::*;
#(
    parameter int N_REQ  = 8,
    parameter int M_MAX  = 3,
    parameter int DATA_W = 16,
    parameter int SLOT_W = cnt_width(M_MAX) + 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_REQ-1:0]              req,
    input  logic [N_REQ-1:0][DATA_W-1:0]  req_data,
    input  logic [SLOT_W-1:0]             avail_slots,
    output logic [N_REQ-1:0]              grant,
    output logic [N_REQ-1:0]              ready,
    output logic [M_MAX-1:0]              lane_valid,
    output logic [M_MAX-1:0][DATA_W-1:0]  lane_data
);

    localparam int CW = cnt_width(M_MAX);
    localparam int IW = idx_width(N_REQ);
    localparam int N_ENC = 2;

    logic [IW-1:0]                         head_q;
    logic [IW-1:0]                         head_nxt;
    logic [CW-1:0]                         limit;
    logic [N_REQ-1:0]                      at_or_above;
    logic [N_ENC-1:0][N_REQ-1:0]           enc_req;
    logic [N_ENC-1:0][M_MAX-1:0][N_REQ-1:0] enc_pick;
    logic [N_ENC-1:0][CW-1:0]              enc_cnt;

    // Budget clamp to the fixed maximum.
    always_comb begin
        if (avail_slots > SLOT_W'(M_MAX)) begin
            limit = CW'(M_MAX);
        end else begin
            limit = CW'(avail_slots);
        end
    end

    always_comb begin
        for (int i = 0; i < N_REQ; i++) begin
            at_or_above[i] = (IW'(i) >= head_q);
        end
    end

    genvar ge;
    generate
        for (ge = 0; ge < N_ENC; ge++) begin : g_enc
            localparam enc_view_e VIEW = enc_view_e'(ge);
            if (VIEW == ENC_ABOVE_HEAD) begin : g_masked
                assign enc_req[ge] = req & at_or_above;
            end else begin : g_full
                assign enc_req[ge] = req;
            end
            vcrr_msel_enc #(
                .N_REQ (N_REQ),
                .M_MAX (M_MAX),
                .CW    (CW)
            ) u_enc (
                .clk      (clk),
                .rst      (rst),
                .req_vec  (enc_req[ge]),
                .limit    (limit),
                .pick     (enc_pick[ge]),
                .pick_cnt (enc_cnt[ge])
            );
        end
    endgenerate

    vcrr_merge #(
        .N_REQ  (N_REQ),
        .M_MAX  (M_MAX),
        .DATA_W (DATA_W),
        .CW     (CW),
        .IW     (IW)
    ) u_merge (
        .clk        (clk),
        .rst        (rst),
        .pick_hi    (enc_pick[ENC_ABOVE_HEAD]),
        .cnt_hi     (enc_cnt[ENC_ABOVE_HEAD]),
        .pick_all   (enc_pick[ENC_ALL]),
        .limit      (limit),
        .head       (head_q),
        .req_data   (req_data),
        .grant      (grant),
        .lane_valid (lane_valid),
        .lane_data  (lane_data),
        .head_nxt   (head_nxt)
    );

    assign ready = grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
        end else begin
            head_q <= head_nxt;
        end
    end

    // R2: grants only where requested
    a_r2_grant_subset: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

    // R1: grant count is the smaller of budget and request count
    a_r1_grant_count: assert property (@(posedge clk) disable iff (rst)
        ($countones(grant) == (($countones(req) < int'(limit)) ?
                               $countones(req) : int'(limit))));

    // R5: idle cycle leaves the head in place
    a_r5_head_hold: assert property (@(posedge clk) disable iff (rst)
        ((req == '0) || (limit == '0)) |=> $stable(head_q));

    // R9: reset returns the head to index 0
    a_r9_reset_head: assert property (@(posedge clk)
        rst |=> (head_q == '0));

endmodule

// File: tb/vcrr_arbiter_tb.sv
module vcrr_arbiter_tb;

    localparam int N  = 8;
    localparam int M  = 3;
    localparam int DW = 16;
    localparam int SW = 3;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [N-1:0]           req = '0;
    logic [N-1:0][DW-1:0]   req_data = '0;
    logic [SW-1:0]          avail_slots = '0;
    logic [N-1:0]           grant;
    logic [N-1:0]           ready;
    logic [M-1:0]           lane_valid;
    logic [M-1:0][DW-1:0]   lane_data;

    int n_chk = 0;
    int n_fail = 0;
    int mhead = 0;
    int waitc [N];
    int maxwait = 0;
    logic [7:0] salt = 8'h10;
    logic [15:0] lfsr = 16'hACE1;

    vcrr_arbiter #(
        .N_REQ  (N),
        .M_MAX  (M),
        .DATA_W (DW),
        .SLOT_W (SW)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .req_data    (req_data),
        .avail_slots (avail_slots),
        .grant       (grant),
        .ready       (ready),
        .lane_valid  (lane_valid),
        .lane_data   (lane_data)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, compare against the scan model, then advance.
    task automatic step(input logic [N-1:0] r, input int a, input string tag);
        int k, cnt, last, idx;
        logic [N-1:0] expg;
        logic [M-1:0] expv;
        logic [M-1:0][DW-1:0] expd;
        @(negedge clk);
        req = r;
        avail_slots = SW'(a);
        for (int i = 0; i < N; i++) req_data[i] = {salt, 8'(i)};
        salt = salt + 8'd1;
        #2;
        k = (a > M) ? M : a;
        cnt = 0; last = -1; expg = '0; expv = '0; expd = '0;
        for (int o = 0; o < N; o++) begin
            idx = (mhead + o) % N;
            if (r[idx] && cnt < k) begin
                expg[idx] = 1'b1;
                expv[cnt] = 1'b1;
                expd[cnt] = req_data[idx];
                cnt++;
                last = idx;
            end
        end
        chk(grant == expg, tag, "grant vector", int'(grant), int'(expg));
        chk($countones(grant) == cnt, "R1", "grant count", $countones(grant), cnt);
        chk((grant & ~r) == '0, "R2", "grant outside request", int'(grant), int'(r));
        chk(ready == grant, "R8", "ready vs grant", int'(ready), int'(grant));
        chk(lane_valid == expv, "R7", "lane valid", int'(lane_valid), int'(expv));
        for (int s = 0; s < M; s++) begin
            if (expv[s]) chk(lane_data[s] == expd[s], "R7", "lane data",
                             int'(lane_data[s]), int'(expd[s]));
        end
        for (int i = 0; i < N; i++) begin
            if (r[i] && k > 0 && !grant[i]) begin
                waitc[i]++;
                if (waitc[i] > maxwait) maxwait = waitc[i];
            end else if (r[i] && grant[i]) begin
                waitc[i] = 0;
                if (maxwait < 1) maxwait = 1;
            end else if (!r[i]) begin
                waitc[i] = 0;
            end
        end
        @(posedge clk);
        if (cnt > 0) mhead = (last + 1) % N;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req = '0;
        avail_slots = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mhead = 0;
        for (int i = 0; i < N; i++) waitc[i] = 0;
        maxwait = 0;
    endtask

    task automatic t_reset();
        do_reset();
        step('1, 2, "R9");
        chk(mhead == 2, "R9", "scan started at 0", mhead, 2);
    endtask

    task automatic t_rotation();
        do_reset();
        step('1, 3, "R4");
        step('1, 3, "R4");
        step('1, 3, "R4");
        step(8'b0001_0100, 3, "R4");
    endtask

    task automatic t_wrap();
        do_reset();
        step(8'b0011_1111, 3, "R3");
        step(8'b0011_1111, 3, "R3");
        step(8'b1000_0011, 3, "R3");
        step(8'b1100_0001, 3, "R3");
        step(8'b0000_0110, 3, "R3");
    endtask

    task automatic t_idle();
        do_reset();
        step('1, 2, "R5");
        step('1, 0, "R5");
        step('0, 3, "R5");
        step(8'b0000_0001, 1, "R5");
        step('1, 1, "R5");
    endtask

    task automatic t_clamp();
        do_reset();
        step('1, 7, "R6");
        step('1, 4, "R6");
        step(8'b0101_0101, 7, "R6");
    endtask

    task automatic t_random();
        do_reset();
        for (int c = 0; c < 300; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[7:0], int'(lfsr[10:8]) % 6, "R3");
        end
    endtask

    task automatic t_starve();
        do_reset();
        for (int c = 0; c < 40; c++) step('1, 1, "R10");
        for (int c = 0; c < 60; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[7:0] | 8'b0010_0000, 1 + (c % 3), "R10");
        end
        chk(maxwait <= N, "R10", "longest wait", maxwait, N);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_rotation();
        t_wrap();
        t_idle();
        t_clamp();
        t_random();
        t_starve();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule